// File: doc/BRIEF.md
# Block Transfer Engine with Byte-Lane Packing and Early Stop

The engine moves a run of bytes or 16-bit words between a streaming buffer and a memory that is 16 bits wide and addressed by word. A caller presents a byte start address, a byte count, a direction, a byte/word selector and a request for mapped addressing, then pulses `start`. The engine then walks the block one element per clock, pacing itself on the valid/ready handshake of the buffer stream. In byte mode each element goes to or from one byte lane of a memory word, and a byte enable protects the other lane.

When mapped addressing is requested and the map is switched on, every element address goes out on a translation port and the returned physical address is used. Otherwise the bus address is used as the physical address. Memory exists only below `MEM_BYTES`. A mapped transfer stops at the first element that translates outside memory. A physical transfer is clipped in advance to the part that lies inside memory. At the end the engine pulses `done` and reports the number of bytes it did not move.

Top module: `dmx_block_engine`

## Requirements
- R1: In byte mode a transfer toward the buffer returns the memory byte in `out_data[7:0]` with `out_data[15:8]` zero. An odd physical address selects memory bits 15:8 and an even address selects bits 7:0.
- R2: In byte mode a transfer toward memory writes `in_data[7:0]` into exactly one lane: `mem_be` = 2'b10 for an odd address and 2'b01 for an even one. The other byte of that word keeps its value.
- R3: In word mode bit 0 of the start address is cleared and the byte count is rounded down to even before the transfer. Each element uses `mem_be` = 2'b11, and the address advances by 2. `in_data[7:0]` and `out_data[7:0]` map to the even byte.
- R4: Translation is used only when `map_req` and `map_on` are both high at `start`. `xl_addr` carries the bus address and `xl_phys` returns the physical byte address. In every other case the bus address is the physical address.
- R5: In a translated transfer, an element whose physical address is at or above `MEM_BYTES` is not accessed. The transfer ends there with a residual equal to the block end minus that element's bus address.
- R6: A translated transfer that reaches the end of the block reports a residual of zero.
- R7: An untranslated transfer whose end address is at or below `MEM_BYTES` moves every element and reports zero.
- R8: An untranslated transfer that starts inside memory but ends beyond it moves the elements below `MEM_BYTES`. Its residual is the block end minus `MEM_BYTES`.
- R9: An untranslated transfer that starts at or above `MEM_BYTES` performs no memory access. Its residual equals the (rounded) byte count.
- R10: At most one element moves per clock, and only on a handshake: `out_valid && out_ready` toward the buffer, `in_valid && in_ready` toward memory. `mem_en` is high exactly on those cycles. A stalled element keeps its address.
- R11: `done` is high for exactly one cycle, with `residual` valid in that cycle. A `start` pulse while a transfer is in progress has no effect.
- R12: After reset, `done`, `mem_en`, `out_valid` and `in_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (taken when idle) |
| start_addr | input | ADDR_W | Byte start address on the bus |
| byte_count | input | ADDR_W | Number of bytes |
| to_memory | input | 1 | 1: buffer to memory, 0: memory to buffer |
| word_mode | input | 1 | 1: 16-bit elements, 0: bytes |
| map_req | input | 1 | Caller asks for translated addressing |
| map_on | input | 1 | Translation map switched on |
| xl_addr | output | ADDR_W | Bus address offered for translation |
| xl_phys | input | ADDR_W | Translated physical byte address |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-1 | Memory word address |
| mem_be | output | 2 | Byte lane enables (bit 1 = bits 15:8) |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid in the same cycle as the address |
| out_valid | output | 1 | Element offered to the buffer |
| out_ready | input | 1 | Buffer accepts the element |
| out_data | output | 16 | Element toward the buffer |
| in_valid | input | 1 | Buffer offers an element |
| in_ready | output | 1 | Engine takes the element |
| in_data | input | 16 | Element from the buffer |
| done | output | 1 | One-cycle end-of-transfer pulse |
| residual | output | ADDR_W | Bytes not transferred |

## Verification
The assertions assume three things:
- Memory read data is valid combinationally in the cycle of the access.
- The translation port answers in the same cycle.
- In an untranslated transfer nothing outside the engine moves the element address while an element is stalled.

The bench meets these assumptions with a combinational memory model and a fixed additive translation. It toggles `out_ready` and `in_valid` only from its own cycle counter. The requested blocks are chosen so that the physical end of each block stays within the address width.

// File: rtl/dmx_pkg.sv
package dmx_pkg;

    localparam int WORD_W = 16;
    localparam int LANE_W = 8;
    localparam int LANES  = WORD_W / LANE_W;

    typedef enum logic {
        ENG_IDLE,
        ENG_RUN
    } eng_state_e;

    // Address increment for one element: 2 in word mode, 1 in byte mode.
    function automatic logic [1:0] elem_step(input logic word);
        return word ? 2'd2 : 2'd1;
    endfunction

endpackage

// File: rtl/dmx_planner.sv
module dmx_planner #(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 4096
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] count,
    input  logic              word,
    input  logic              mapped,
    output logic [ADDR_W:0]   base,
    output logic [ADDR_W:0]   lim,
    output logic [ADDR_W:0]   stop
);
    localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

    logic [ADDR_W:0] cnt;

    always_comb begin
        base = {1'b0, addr[ADDR_W-1:1], addr[0] & ~word};
        cnt  = {1'b0, count[ADDR_W-1:1], count[0] & ~word};
        lim  = base + cnt;
        if (mapped)
            stop = lim;           // translated: checked element by element
        else if (lim <= MEM_LIM)
            stop = lim;
        else if (base < MEM_LIM)
            stop = MEM_LIM;
        else
            stop = base;          // nothing inside memory
    end
endmodule

// File: rtl/dmx_lane.sv
module dmx_lane
    import dmx_pkg::*;
(
    input  logic              word,
    input  logic              odd,
    input  logic [WORD_W-1:0] rdata,
    input  logic [WORD_W-1:0] buf_in,
    output logic [LANES-1:0]  be,
    output logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rd_out
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign be[g] = word | (odd == (g % 2 == 1));
        assign wdata[g*LANE_W +: LANE_W] = word ? buf_in[g*LANE_W +: LANE_W]
                                                : buf_in[LANE_W-1:0];
    end

    always_comb begin
        if (word)
            rd_out = rdata;
        else
            rd_out = {{(WORD_W-LANE_W){1'b0}},
                      odd ? rdata[WORD_W-1:LANE_W] : rdata[LANE_W-1:0]};
    end

    always_comb begin
        a_r2_single_lane: assert (word || $countones(be) == 1);
    end
endmodule

// File: rtl/dmx_block_engine.sv
module dmx_block_engine
    import dmx_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int MEM_BYTES = 4096
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [ADDR_W-1:0] byte_count,
    input  logic              to_memory,
    input  logic              word_mode,
    input  logic              map_req,
    input  logic              map_on,
    output logic [ADDR_W-1:0] xl_addr,
    input  logic [ADDR_W-1:0] xl_phys,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-2:0] mem_addr,
    output logic [1:0]        mem_be,
    output logic [15:0]       mem_wdata,
    input  logic [15:0]       mem_rdata,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [15:0]       out_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [15:0]       in_data,
    output logic              done,
    output logic [ADDR_W-1:0] residual
);
    localparam logic [ADDR_W:0] MEM_LIM = (ADDR_W+1)'(MEM_BYTES);

    typedef struct packed {
        logic [ADDR_W:0] cur;
        logic [ADDR_W:0] lim;
        logic [ADDR_W:0] stop;
        logic            word;
        logic            to_mem;
        logic            mapped;
    } job_t;

    eng_state_e      state;
    job_t            job;
    logic [ADDR_W:0] p_base, p_lim, p_stop, rem;
    logic [ADDR_W-1:0] phys;
    logic            use_map, at_end, nxm, active, fire;

    assign use_map = map_req & map_on;

    dmx_planner #(.ADDR_W(ADDR_W), .MEM_BYTES(MEM_BYTES)) u_plan (
        .addr(start_addr), .count(byte_count), .word(word_mode),
        .mapped(use_map), .base(p_base), .lim(p_lim), .stop(p_stop)
    );

    assign xl_addr = job.cur[ADDR_W-1:0];
    assign phys    = job.mapped ? xl_phys : job.cur[ADDR_W-1:0];
    assign nxm     = job.mapped && ({1'b0, xl_phys} >= MEM_LIM);
    assign at_end  = job.cur >= job.stop;
    assign active  = (state == ENG_RUN) && !at_end && !nxm;
    assign rem     = job.lim - job.cur;

    assign out_valid = active & ~job.to_mem;
    assign in_ready  = active &  job.to_mem;
    assign fire      = job.to_mem ? (in_ready & in_valid) : (out_valid & out_ready);

    assign mem_en   = fire;
    assign mem_we   = job.to_mem;
    assign mem_addr = phys[ADDR_W-1:1];

    dmx_lane u_lane (
        .word(job.word), .odd(phys[0]), .rdata(mem_rdata), .buf_in(in_data),
        .be(mem_be), .wdata(mem_wdata), .rd_out(out_data)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ENG_IDLE;
            job      <= '0;
            done     <= 1'b0;
            residual <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ENG_IDLE: if (start) begin
                    job.cur    <= p_base;
                    job.lim    <= p_lim;
                    job.stop   <= p_stop;
                    job.word   <= word_mode;
                    job.to_mem <= to_memory;
                    job.mapped <= use_map;
                    state      <= ENG_RUN;
                end
                ENG_RUN: begin
                    if (at_end || nxm) begin
                        state    <= ENG_IDLE;
                        done     <= 1'b1;
                        residual <= rem[ADDR_W-1:0];
                    end else if (fire) begin
                        job.cur <= job.cur + (ADDR_W+1)'(elem_step(job.word));
                    end
                end
                default: state <= ENG_IDLE;
            endcase
        end
    end

    // R11: end-of-transfer strobe lasts a single cycle
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R8 / R5: no access ever reaches beyond installed memory
    a_r8_mem_in_range: assert property (@(posedge clk) disable iff (rst)
        mem_en |-> (int'(mem_addr) < MEM_BYTES / 2));
    // R3: word accesses use both lanes at an even address
    a_r3_word_lanes: assert property (@(posedge clk) disable iff (rst)
        (mem_en && job.word) |-> (mem_be == 2'b11 && !phys[0]));
    // R10: a stalled untranslated read element stays put
    a_r10_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !job.mapped) |=> (out_valid && $stable(mem_addr)));
    // R10: buffer handshakes are one-sided by direction
    a_r10_one_side: assert property (@(posedge clk) disable iff (rst)
        !(out_valid && in_ready));
    // R12 / R11: no activity while idle
    a_r12_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        (state == ENG_IDLE) |-> (!mem_en && !out_valid && !in_ready));
endmodule

// File: tb/dmx_block_engine_test.sv
module dmx_block_engine_test;
    localparam int AW   = 12;
    localparam int MEMB = 64;
    localparam int XOFF = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic start = 0, to_memory = 0, word_mode = 0, map_req = 0, map_on = 0;
    logic [AW-1:0] start_addr = '0, byte_count = '0;
    logic [AW-1:0] xl_addr, xl_phys, residual;
    logic mem_en, mem_we, out_valid, out_ready, in_valid, in_ready, done;
    logic [AW-2:0] mem_addr;
    logic [1:0] mem_be;
    logic [15:0] mem_wdata, mem_rdata, out_data, in_data;

    dmx_block_engine #(.ADDR_W(AW), .MEM_BYTES(MEMB)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .to_memory(to_memory), .word_mode(word_mode),
        .map_req(map_req), .map_on(map_on), .xl_addr(xl_addr), .xl_phys(xl_phys),
        .mem_en(mem_en), .mem_we(mem_we), .mem_addr(mem_addr), .mem_be(mem_be),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .out_valid(out_valid),
        .out_ready(out_ready), .out_data(out_data), .in_valid(in_valid),
        .in_ready(in_ready), .in_data(in_data), .done(done), .residual(residual)
    );

    int checks = 0, fails = 0;
    logic [15:0] mem [0:MEMB/2-1];
    logic [7:0]  sh  [0:MEMB-1];
    logic [15:0] exp_q[$];
    int          res_q[$];
    int acc_cnt = 0, src_idx = 0, cyc = 0;
    bit stall = 0, done_seen = 0, finished = 0;
    logic gate;

    assign xl_phys   = xl_addr + AW'(XOFF);
    assign mem_rdata = (int'(mem_addr) < MEMB/2) ? mem[mem_addr] : 16'hDEAD;
    assign gate      = !stall || (cyc % 3 != 0);
    assign out_ready = gate;
    assign in_valid  = gate;
    assign in_data   = {8'(src_idx + 64), 8'(src_idx + 144)};

    function automatic logic [7:0] init_byte(input int b);
        return 8'(b * 7 + 3);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (in_valid && in_ready) src_idx <= src_idx + 1;
        if (mem_en && mem_we && int'(mem_addr) < MEMB/2) begin
            if (mem_be[0]) mem[mem_addr][7:0]  <= mem_wdata[7:0];
            if (mem_be[1]) mem[mem_addr][15:8] <= mem_wdata[15:8];
        end
    end

    // monitor: pops the scoreboard as results appear
    always @(negedge clk) begin
        if (!rst) begin
            if (mem_en) acc_cnt++;
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) chk(0, "R10 unexpected element", out_data, -1);
                else begin
                    automatic logic [15:0] e = exp_q.pop_front();
                    chk(out_data == e, "R1/R3 read element", out_data, e);
                end
            end
            if (done) begin
                if (res_q.size() == 0) chk(0, "R11 unexpected done", residual, -1);
                else begin
                    automatic int r = res_q.pop_front();
                    chk(int'(residual) == r, "R5-R9 residual", residual, r);
                end
                done_seen = 1;
            end
        end
    end

    // driver: builds the expected items from the requirements
    task automatic run(input int a0, input int c0, input bit wr, input bit wd,
                       input bit mreq, input bit mon, input bit stl, input bit poke);
        int a, c, lim, s, res, n, k, alim, bad;
        a = wd ? (a0 & ~1) : a0;
        c = wd ? (c0 & ~1) : c0;
        lim = a + c; s = wd ? 2 : 1; n = 0; k = 0;
        if (mreq && mon) begin
            res = 0;
            for (int cur = a; cur < lim; cur += s) begin
                automatic int p = cur + XOFF;
                if (p >= MEMB) begin res = lim - cur; break; end
                if (wr) begin
                    sh[p] = 8'(k + 144);
                    if (wd) sh[p+1] = 8'(k + 64);
                end else exp_q.push_back(wd ? {sh[p+1], sh[p]} : {8'h00, sh[p]});
                k++; n++;
            end
        end else begin
            alim = (lim <= MEMB) ? lim : (a < MEMB) ? MEMB : a;
            res = lim - alim;
            for (int p = a; p < alim; p += s) begin
                if (wr) begin
                    sh[p] = 8'(k + 144);
                    if (wd) sh[p+1] = 8'(k + 64);
                end else exp_q.push_back(wd ? {sh[p+1], sh[p]} : {8'h00, sh[p]});
                k++; n++;
            end
        end
        res_q.push_back(res);
        @(negedge clk);
        acc_cnt = 0; src_idx = 0; done_seen = 0; stall = stl;
        start_addr = AW'(a0); byte_count = AW'(c0); to_memory = wr;
        word_mode = wd; map_req = mreq; map_on = mon; start = 1;
        @(negedge clk); start = 0;
        if (poke) begin
            repeat (3) @(negedge clk);
            // R11: this start arrives mid-transfer and must be ignored
            start_addr = 12'd40; byte_count = 12'd3; to_memory = ~wr; word_mode = ~wd;
            start = 1;
            @(negedge clk); start = 0;
        end
        wait (done_seen);
        @(negedge clk);
        chk(!done, "R11 done single cycle", done, 0);
        chk(acc_cnt == n, "R9/R10 access count", acc_cnt, n);
        chk(exp_q.size() == 0, "R10 all elements delivered", exp_q.size(), 0);
        if (wr) begin
            bad = 0;
            for (int b = 0; b < MEMB; b++)
                if ((b % 2 ? mem[b/2][15:8] : mem[b/2][7:0]) != sh[b]) bad++;
            chk(bad == 0, "R2/R3 memory image", bad, 0);
        end
        stall = 0;
        exp_q.delete();
    endtask

    initial begin
        for (int i = 0; i < MEMB/2; i++) mem[i] = {init_byte(2*i+1), init_byte(2*i)};
        for (int b = 0; b < MEMB; b++) sh[b] = init_byte(b);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R12 reset state
        chk(!done && !mem_en && !out_valid && !in_ready, "R12 idle after reset",
            {done, mem_en, out_valid, in_ready}, 0);
        run(5, 7, 0, 0, 0, 0, 0, 0);    // R1 R7 byte read, odd and even lanes
        run(3, 5, 1, 0, 0, 0, 1, 0);    // R2 R10 byte write with stalls
        run(9, 9, 0, 1, 0, 0, 0, 0);    // R3 word read, aligned and rounded
        run(21, 7, 1, 1, 0, 0, 1, 0);   // R3 word write
        run(58, 12, 0, 0, 0, 0, 0, 0);  // R8 byte read clipped, residual 6
        run(60, 10, 1, 1, 0, 0, 0, 0);  // R8 word write clipped, residual 6
        run(70, 5, 0, 0, 0, 0, 0, 0);   // R9 start outside memory
        run(2, 8, 0, 0, 1, 1, 0, 0);    // R4 R6 translated read, residual 0
        run(2, 4, 0, 0, 1, 0, 0, 0);    // R4 map off: physical addresses
        run(48, 12, 1, 1, 1, 1, 0, 0);  // R5 translated write stops, residual 6
        run(0, 20, 0, 0, 0, 0, 1, 1);   // R11 start while busy ignored, R10 stalls
        run(7, 0, 0, 0, 0, 0, 0, 0);    // R7 empty block
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule